// File: doc/BRIEF.md
# Processor Interrupt Front End

This block sits between an interrupt distributor and one processor. The distributor presents a pending bit and an 8-bit priority for every interrupt line. The block picks the most urgent line that is pending and not already being serviced. It compares that line's priority against a software threshold and against the priority of the interrupt now being handled. If the line passes both tests, the block drives a request line to the processor. A lower priority number means a more urgent interrupt.

Software drives the block through a small register bus. A read of the acknowledge register claims the winning interrupt and returns its number. The same read marks the interrupt active, raises the running priority to that interrupt's level, and sends a one-cycle claim pulse to the distributor so it can drop the pending bit. A write of the interrupt number to the completion register retires it and returns the running priority to idle. Two read-only registers show the running priority and the best pending candidate.

Top module: `cpuif_unit`

## Requirements
- R1: After reset the control register reads 0, the threshold reads 0, the running priority reads 0xFF, the highest-pending register reads 1023 with no line pending, no interrupt is active and `irq_o` is low.
- R2: Bit 0 of the control register (offset 0x000) gates signalling; while it is 0, `irq_o` stays low whatever is pending.
- R3: The threshold register (offset 0x004, bits [7:0]) lets a candidate through only when its priority is numerically below the threshold, so 255 admits every priority except 255 and 0 admits none.
- R4: A read of offset 0x00C while `irq_o` is high returns the winning ID in bits [9:0] with upper bits zero, makes that interrupt active, sets the running priority to its priority, and pulses `ack_valid_o` with `ack_id_o` equal to that ID in the same cycle as the read data.
- R5: A read of offset 0x00C when no candidate qualifies (disabled, masked, or not more urgent than the running priority) returns 1023, raises no claim pulse and changes no state.
- R6: A candidate is signalled only if its priority is numerically below the running priority; an equal priority does not preempt.
- R7: Writing the ID of an active interrupt to offset 0x010 clears its active state and returns the running priority to 0xFF.
- R8: Writing an ID to offset 0x010 that is not active, including IDs beyond the implemented lines, changes neither the active set nor the running priority.
- R9: Among pending, non-active lines the lowest priority value wins, and on equal priority the lowest ID wins.
- R10: Offset 0x014 reads the running priority in bits [7:0]; offset 0x018 reads the winning pending, non-active ID regardless of enable and threshold, or 1023 when none; writes to both offsets are ignored.
- R11: Every read returns its data with `bus_rvalid` high on the cycle after the request; offsets with no register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pend_i | input | N_IRQ | Pending bit per line from the distributor |
| prio_i | input | N_IRQ*PRIO_W | Priority per line, line i at bits [i*PRIO_W +: PRIO_W] |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_valid_o | output | 1 | Claim pulse to the distributor |
| ack_id_o | output | ID_W | ID claimed by the pulse |

## Verification
On every cycle the assertions check that the request stays low while disabled, that a claimed ID is active, that a read with no request returns 1023 without a claim, that a read with a request produces a matching claim, and that completion writes either idle the running priority or leave all state alone. The bench scenarios show what cycle checks cannot. These are the threshold comparison swept over every priority value, the arbitration order over many pending patterns, the preemption rule against an active interrupt, and the read-only behaviour of the status offsets.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
    localparam int unsigned ID_W = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    localparam logic [11:0] OFS_CTRL = 12'h000;
    localparam logic [11:0] OFS_MASK = 12'h004;
    localparam logic [11:0] OFS_ACK  = 12'h00C;
    localparam logic [11:0] OFS_EOI  = 12'h010;
    localparam logic [11:0] OFS_RUN  = 12'h014;
    localparam logic [11:0] OFS_HIGH = 12'h018;
endpackage

// File: rtl/cpuif_pick.sv
// Finds the most urgent candidate: smallest priority value, lowest index on ties.
module cpuif_pick #(
    parameter int unsigned N_IRQ  = 16,
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned ID_W   = 10
) (
    input  logic [N_IRQ-1:0]        cand,
    input  logic [N_IRQ*PRIO_W-1:0] prio,
    output logic                    found,
    output logic [ID_W-1:0]         best_id,
    output logic [PRIO_W-1:0]       best_lvl
);
    always_comb begin
        found    = 1'b0;
        best_id  = '0;
        best_lvl = '1;
        for (int i = 0; i < int'(N_IRQ); i++) begin
            // strict compare keeps the earlier (lower) index on equal priority
            if (cand[i] && (!found || prio[i*PRIO_W +: PRIO_W] < best_lvl)) begin
                found    = 1'b1;
                best_id  = ID_W'(i);
                best_lvl = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/cpuif_rdmux.sv
// Read data selection by register offset.
module cpuif_rdmux
    import cpuif_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PRIO_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic [PRIO_W-1:0] mask,
    input  logic [PRIO_W-1:0] run,
    input  logic [ID_W-1:0]   ack_word,
    input  logic [ID_W-1:0]   high_word,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        data = '0;
        if (addr == ADDR_W'(OFS_CTRL))      data = DATA_W'(en);
        else if (addr == ADDR_W'(OFS_MASK)) data = DATA_W'(mask);
        else if (addr == ADDR_W'(OFS_ACK))  data = DATA_W'(ack_word);
        else if (addr == ADDR_W'(OFS_RUN))  data = DATA_W'(run);
        else if (addr == ADDR_W'(OFS_HIGH)) data = DATA_W'(high_word);
    end
endmodule

// File: rtl/cpuif_unit.sv
module cpuif_unit
    import cpuif_pkg::*;
#(
    parameter int unsigned N_IRQ  = 16,
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_rvalid,
    input  logic [N_IRQ-1:0]        pend_i,
    input  logic [N_IRQ*PRIO_W-1:0] prio_i,
    output logic                    irq_o,
    output logic                    ack_valid_o,
    output logic [ID_W-1:0]         ack_id_o
);
    localparam int unsigned SEL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
    localparam logic [PRIO_W-1:0] IDLE_LVL = '1;

    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] mask;
        logic [PRIO_W-1:0] run;
        logic [N_IRQ-1:0]  act;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              ackv;
        logic [ID_W-1:0]   ackid;
    } state_t;

    state_t st_d, st_q;

    logic              found;
    logic [ID_W-1:0]   best_id;
    logic [PRIO_W-1:0] best_lvl;
    logic              take;
    logic [ID_W-1:0]   ack_word;
    logic [ID_W-1:0]   high_word;
    logic [DATA_W-1:0] rd_word;
    logic              rd_req, wr_req, eoi_live;

    cpuif_pick #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) i_pick (
        .cand    (pend_i & ~st_q.act),
        .prio    (prio_i),
        .found   (found),
        .best_id (best_id),
        .best_lvl(best_lvl)
    );

    // a winner that fails either test means every other candidate fails too
    assign take      = st_q.en && found && (best_lvl < st_q.mask) && (best_lvl < st_q.run);
    assign ack_word  = take  ? best_id : SPURIOUS_ID;
    assign high_word = found ? best_id : SPURIOUS_ID;
    assign rd_req    = bus_valid && !bus_write;
    assign wr_req    = bus_valid && bus_write;
    assign eoi_live  = (bus_wdata[ID_W-1:0] < ID_W'(N_IRQ)) && st_q.act[bus_wdata[SEL_W-1:0]];

    cpuif_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) i_rdmux (
        .addr     (bus_addr),
        .en       (st_q.en),
        .mask     (st_q.mask),
        .run      (st_q.run),
        .ack_word (ack_word),
        .high_word(high_word),
        .data     (rd_word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.ackv   = 1'b0;
        if (rd_req) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_word;
            if (bus_addr == ADDR_W'(OFS_ACK) && take) begin
                st_d.act[best_id[SEL_W-1:0]] = 1'b1;
                st_d.run   = best_lvl;
                st_d.ackv  = 1'b1;
                st_d.ackid = best_id;
            end
        end
        if (wr_req) begin
            if (bus_addr == ADDR_W'(OFS_CTRL)) begin
                st_d.en = bus_wdata[0];
            end else if (bus_addr == ADDR_W'(OFS_MASK)) begin
                st_d.mask = bus_wdata[PRIO_W-1:0];
            end else if (bus_addr == ADDR_W'(OFS_EOI) && eoi_live) begin
                st_d.act[bus_wdata[SEL_W-1:0]] = 1'b0;
                st_d.run = IDLE_LVL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.run   <= IDLE_LVL;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o       = take;
    assign bus_rdata   = st_q.rdata;
    assign bus_rvalid  = st_q.rvalid;
    assign ack_valid_o = st_q.ackv;
    assign ack_id_o    = st_q.ackid;

    // plain views of state for the bound checker
    logic              en_w;
    logic [PRIO_W-1:0] run_w;
    logic [N_IRQ-1:0]  act_w;
    assign en_w  = st_q.en;
    assign run_w = st_q.run;
    assign act_w = st_q.act;
endmodule

// File: rtl/cpuif_chk.sv
module cpuif_chk
    import cpuif_pkg::*;
#(
    parameter int unsigned N_IRQ  = 16,
    parameter int unsigned PRIO_W = 8,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              irq_o,
    input logic              ack_valid_o,
    input logic [ID_W-1:0]   ack_id_o,
    input logic              en_w,
    input logic [PRIO_W-1:0] run_w,
    input logic [N_IRQ-1:0]  act_w
);
    localparam int unsigned SEL_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    logic rd_any, rd_ack, wr_eoi, eoi_hit;
    assign rd_any  = bus_valid && !bus_write;
    assign rd_ack  = rd_any && (bus_addr == ADDR_W'(OFS_ACK));
    assign wr_eoi  = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_EOI));
    assign eoi_hit = (bus_wdata[ID_W-1:0] < ID_W'(N_IRQ)) && act_w[bus_wdata[SEL_W-1:0]];

    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w |-> !irq_o);

    a_r4_claim_is_active: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> act_w[ack_id_o[SEL_W-1:0]]);

    a_r4_claim_matches_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && irq_o) |=> (ack_valid_o && bus_rdata[ID_W-1:0] == ack_id_o));

    a_r5_spurious_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !irq_o) |=> (bus_rdata == DATA_W'(SPURIOUS_ID) && !ack_valid_o));

    a_r7_eoi_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_eoi && eoi_hit) |=> (run_w == '1));

    a_r8_eoi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_eoi && !eoi_hit) |=> ($stable(run_w) && $stable(act_w)));

    a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_any |=> bus_rvalid);
endmodule

bind cpuif_unit cpuif_chk #(
    .N_IRQ(N_IRQ), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .irq_o      (irq_o),
    .ack_valid_o(ack_valid_o),
    .ack_id_o   (ack_id_o),
    .en_w       (en_w),
    .run_w      (run_w),
    .act_w      (act_w)
);

// File: tb/test_cpuif_unit.sv
module test_cpuif_unit;
    localparam int N = 16;
    localparam int PW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [N-1:0]      pend = '0;
    logic [N*PW-1:0]   prio = '0;
    logic              irq_o;
    logic              ack_valid_o;
    logic [9:0]        ack_id_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cpuif_unit #(.N_IRQ(N), .PRIO_W(PW)) i_cpuif_unit (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pend_i(pend), .prio_i(prio),
        .irq_o(irq_o), .ack_valid_o(ack_valid_o), .ack_id_o(ack_id_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic rv,
                      output logic av, output logic [9:0] aid);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata; rv = bus_rvalid; av = ack_valid_o; aid = ack_id_o;
        #1;
    endtask

    task automatic setp(input int id, input logic [7:0] p);
        prio[id*PW +: PW] = p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic rv, av;
        logic [9:0] aid;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk("R1 irq", irq_o, 0);
        rd(12'h000, d, rv, av, aid); chk("R1 ctrl", d, 0);
        rd(12'h004, d, rv, av, aid); chk("R1 mask", d, 0);
        rd(12'h014, d, rv, av, aid); chk("R1 running", d, 32'hFF);
        rd(12'h018, d, rv, av, aid); chk("R1 highest", d, 1023);

        // R11 unused offset and read valid
        rd(12'h020, d, rv, av, aid); chk("R11 unused", d, 0); chk("R11 rvalid", rv, 1);

        // R2 enable gating, R5 spurious when disabled, R10 highest ignores enable
        setp(3, 8'h10); pend[3] = 1'b1;
        wr(12'h004, 32'hFF);
        chk("R2 off", irq_o, 0);
        rd(12'h00C, d, rv, av, aid); chk("R5 disabled ack", d, 1023); chk("R5 no claim", av, 0);
        rd(12'h018, d, rv, av, aid); chk("R10 highest while off", d, 3);
        wr(12'h000, 32'h1); chk("R2 on", irq_o, 1);
        wr(12'h000, 32'h0); chk("R2 off again", irq_o, 0);
        wr(12'h000, 32'h1);

        // R3 threshold sweep over every priority value
        for (int p = 0; p < 256; p++) begin
            setp(3, 8'(p));
            for (int j = 0; j < 4; j++) begin
                int m;
                m = (j == 0) ? 0 : (j == 1) ? p : (j == 2) ? ((p < 255) ? p + 1 : 255) : 255;
                wr(12'h004, 32'(m));
                chk($sformatf("R3 p=%0d m=%0d", p, m), irq_o, (p < m) ? 1 : 0);
            end
        end

        // R4 acknowledge
        wr(12'h004, 32'hFF);
        setp(3, 8'h40);
        rd(12'h00C, d, rv, av, aid);
        chk("R4 ack id", d, 3); chk("R4 claim pulse", av, 1); chk("R4 claim id", aid, 3);
        pend[3] = 1'b0;
        rd(12'h014, d, rv, av, aid); chk("R4 running", d, 32'h40);
        rd(12'h018, d, rv, av, aid); chk("R10 none pending", d, 1023);

        // R6 preemption against running priority
        setp(5, 8'h40); pend[5] = 1'b1; #1;
        chk("R6 equal blocked", irq_o, 0);
        rd(12'h00C, d, rv, av, aid); chk("R5 blocked ack", d, 1023);
        rd(12'h014, d, rv, av, aid); chk("R5 running kept", d, 32'h40);
        setp(5, 8'h3F); #1;
        chk("R6 more urgent", irq_o, 1);

        // R8 ignored completions
        wr(12'h010, 32'd5);
        rd(12'h014, d, rv, av, aid); chk("R8 inactive id", d, 32'h40);
        wr(12'h010, 32'd200);
        rd(12'h014, d, rv, av, aid); chk("R8 out of range", d, 32'h40);
        wr(12'h010, 32'd1023);
        rd(12'h014, d, rv, av, aid); chk("R8 spurious id", d, 32'h40);

        // R7 valid completion
        wr(12'h010, 32'd3);
        rd(12'h014, d, rv, av, aid); chk("R7 idle", d, 32'hFF);
        chk("R7 irq back", irq_o, 1);

        // R10 read-only status offsets
        wr(12'h014, 32'h0); wr(12'h018, 32'h0);
        rd(12'h014, d, rv, av, aid); chk("R10 running ro", d, 32'hFF);
        rd(12'h018, d, rv, av, aid); chk("R10 highest ro", d, 5);
        rd(12'h00C, d, rv, av, aid); chk("R4 second ack", d, 5);
        pend[5] = 1'b0;
        wr(12'h010, 32'd5);

        // R10 highest ignores threshold, R3 threshold 0 blocks
        wr(12'h004, 32'h0);
        setp(7, 8'h80); pend[7] = 1'b1; #1;
        chk("R3 mask zero", irq_o, 0);
        rd(12'h018, d, rv, av, aid); chk("R10 highest masked", d, 7);
        rd(12'h00C, d, rv, av, aid); chk("R5 masked ack", d, 1023);
        pend[7] = 1'b0;
        wr(12'h004, 32'hFF);

        // R9 arbitration sweep
        for (int k = 0; k < 64; k++) begin
            int best;
            int blvl;
            logic [N-1:0] pat;
            pat = N'((k * 40503) ^ (k << 3) ^ (k >> 2));
            for (int i = 0; i < N; i++) setp(i, 8'(((i * 7 + k * 3) % 5) * 32));
            pend = pat;
            best = -1; blvl = 256;
            for (int i = 0; i < N; i++)
                if (pat[i] && ((i * 7 + k * 3) % 5) * 32 < blvl) begin
                    best = i; blvl = ((i * 7 + k * 3) % 5) * 32;
                end
            rd(12'h018, d, rv, av, aid);
            chk($sformatf("R9 highest k=%0d", k), d, (best < 0) ? 1023 : best);
            rd(12'h00C, d, rv, av, aid);
            chk($sformatf("R9 ack k=%0d", k), d, (best < 0) ? 1023 : best);
            if (best >= 0) begin
                pend[best] = 1'b0;
                rd(12'h014, d, rv, av, aid);
                chk($sformatf("R4 running k=%0d", k), d, 32'(blvl));
                wr(12'h010, 32'(best));
                rd(12'h014, d, rv, av, aid);
                chk($sformatf("R7 idle k=%0d", k), d, 32'hFF);
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule